// File: doc/BRIEF.md
# Sector Erase Controller with Suspend and Resume

This block sequences the erase of one sector out of an array of independently erasable sectors. A host issues an erase command with a sector number. The block looks up a per-sector protection mask and refuses the command if the sector is protected. Otherwise it starts a staircase of bias steps. During each step it raises `biasOn` and presents a step index on `biasLevel`. The analog side turns that index into a negative gate bias and a rising positive source/substrate bias. After each step the block requests one verify cycle. A passing verify ends the erase. If the verify has not passed after the last step, the erase ends with an error.

While an erase is running, the host may ask for a suspend so that the array can be read. The block does not cut a step short. It finishes the bias step in progress, skips that step's verify, and parks with the bias off and the step index frozen. A later resume repeats the parked step in full and then carries on as normal. Only one erase is held at a time. Other commands that arrive while an erase is running or parked are dropped.

Top module: `sector_erase_ctrl`

## Requirements
- R1: After reset, `busy`, `suspended`, `protReject`, `eraseError`, `biasOn` and `verifyReq` are all 0.
- R2: Command codes on `cmdOp` are 2'b00 none, 2'b01 erase, 2'b10 suspend and 2'b11 resume, and they are sampled while `cmdValid` is 1.
  - An idle erase for a sector whose `protMask` bit is 1 sets `protReject` from the next cycle and leaves `busy` at 0.
  - The next accepted erase clears `protReject` and `eraseError`.
- R3: An accepted erase raises `busy` and `biasOn` in the next cycle with `biasLevel` 0. Each bias step lasts exactly STEP_CYCLES cycles, and each new step has a `biasLevel` one higher than the previous one.
- R4: A one-cycle `verifyReq` follows every completed, unsuspended bias step. If `verifyPass` is 1 in that cycle, `busy` falls in the next cycle and `eraseError` stays 0.
- R5: If the verify of step MAX_STEPS-1 fails, `busy` falls with `eraseError` at 1, after exactly MAX_STEPS verifies.
- R6: An erase command that arrives while busy or suspended is ignored. `activeSector` stays unchanged, and `protReject` is not set even if the named sector is protected.
- R7: A suspend that arrives during an erase takes effect at the end of the current bias step. At that point `suspended` goes to 1 and `busy` and `biasOn` go to 0. No verify is made for that step, and `biasLevel` holds its value while the erase is parked.
- R8: A resume while suspended restarts the parked step in the next cycle, with the same `biasLevel` and a full STEP_CYCLES duration.
- R9: A suspend while idle and a resume while not suspended are ignored. They leave no pending request behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 2 | Command code (see R2) |
| cmdSector | input | 6 | Sector number for an erase |
| protMask | input | 64 | One protection bit per sector |
| verifyPass | input | 1 | Verify result, valid while verifyReq is 1 |
| busy | output | 1 | Erase running |
| suspended | output | 1 | Erase parked |
| protReject | output | 1 | Last erase refused for protection |
| eraseError | output | 1 | Last erase ran out of steps |
| biasOn | output | 1 | Apply erase bias |
| biasLevel | output | 5 | Staircase step index |
| verifyReq | output | 1 | Perform a verify this cycle |
| activeSector | output | 6 | Sector being erased |

## Verification
A wrong step counter shows up on `biasLevel` at the next verify: the level no longer matches the number of verifies already made, and the final level and verify count reported at completion are wrong. A broken step timer changes the number of `biasOn` cycles between two verifies within one step. A lost or stale suspend request appears at the end of the current step, either as a missing `suspended` or as a spurious park. A corrupted sector latch or a command that was wrongly accepted changes `activeSector` in the cycle after the ignored command.

// File: rtl/sec_erase_pkg.sv
package sec_erase_pkg;

  typedef enum logic [1:0] {
    OP_NONE    = 2'b00,
    OP_ERASE   = 2'b01,
    OP_SUSPEND = 2'b10,
    OP_RESUME  = 2'b11
  } cmdOpE;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BIAS,
    ST_VERIFY,
    ST_SUSP
  } eraseStateE;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;
    logic loadTimer;
    logic incStep;
    logic setReject;
    logic setError;
  } dpStrobeT;

endpackage

// File: rtl/sec_erase_dp.sv
module sec_erase_dp
  import sec_erase_pkg::*;
#(
  parameter int NUM_SECTORS = 64,
  parameter int MAX_STEPS   = 32,
  parameter int STEP_CYCLES = 8,
  localparam int SECT_W = $clog2(NUM_SECTORS),
  localparam int STEP_W = $clog2(MAX_STEPS),
  localparam int TMR_W  = $clog2(STEP_CYCLES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobeT               strobe,
  input  logic [SECT_W-1:0]      cmdSector,
  input  logic [NUM_SECTORS-1:0] protMask,
  output logic                   sectorProt,
  output logic                   timerZero,
  output logic                   stepLast,
  output logic [STEP_W-1:0]      stepIdx,
  output logic [SECT_W-1:0]      activeSector,
  output logic                   protReject,
  output logic                   eraseError
);

  logic [TMR_W-1:0] stepTimer;

  assign sectorProt = protMask[cmdSector];
  assign timerZero  = (stepTimer == '0);
  assign stepLast   = (stepIdx == STEP_W'(MAX_STEPS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepTimer <= '0;
    end else if (strobe.loadTimer) begin
      stepTimer <= TMR_W'(STEP_CYCLES - 1);
    end else if (!timerZero) begin
      stepTimer <= stepTimer - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepIdx      <= '0;
      activeSector <= '0;
      protReject   <= 1'b0;
      eraseError   <= 1'b0;
    end else begin
      if (strobe.loadCmd) begin
        stepIdx      <= '0;
        activeSector <= cmdSector;
        protReject   <= 1'b0;
        eraseError   <= 1'b0;
      end else if (strobe.incStep) begin
        stepIdx <= stepIdx + 1'b1;
      end
      if (strobe.setReject) protReject <= 1'b1;
      if (strobe.setError)  eraseError <= 1'b1;
    end
  end

endmodule

// File: rtl/sec_erase_ctrl.sv
module sec_erase_ctrl
  import sec_erase_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       sectorProt,
  input  logic       timerZero,
  input  logic       stepLast,
  input  logic       verifyPass,
  output dpStrobeT   strobe,
  output logic       busy,
  output logic       suspended,
  output logic       biasOn,
  output logic       verifyReq
);

  eraseStateE state, stateNext;
  logic suspPend;
  logic eraseCmd, suspCmd, resumeCmd;

  assign eraseCmd  = cmdValid && (cmdOp == OP_ERASE);
  assign suspCmd   = cmdValid && (cmdOp == OP_SUSPEND);
  assign resumeCmd = cmdValid && (cmdOp == OP_RESUME);

  assign busy      = (state == ST_BIAS) || (state == ST_VERIFY);
  assign suspended = (state == ST_SUSP);
  assign biasOn    = (state == ST_BIAS);
  assign verifyReq = (state == ST_VERIFY);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (eraseCmd) begin
          if (sectorProt) begin
            strobe.setReject = 1'b1;
          end else begin
            strobe.loadCmd   = 1'b1;
            strobe.loadTimer = 1'b1;
            stateNext        = ST_BIAS;
          end
        end
      end
      ST_BIAS: begin
        if (timerZero) stateNext = (suspPend || suspCmd) ? ST_SUSP : ST_VERIFY;
      end
      ST_VERIFY: begin
        if (verifyPass) begin
          stateNext = ST_IDLE;
        end else if (stepLast) begin
          strobe.setError = 1'b1;
          stateNext       = ST_IDLE;
        end else begin
          strobe.incStep   = 1'b1;
          strobe.loadTimer = 1'b1;
          stateNext        = ST_BIAS;
        end
      end
      ST_SUSP: begin
        if (resumeCmd) begin
          strobe.loadTimer = 1'b1;
          stateNext        = ST_BIAS;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      suspPend <= 1'b0;
    end else begin
      state <= stateNext;
      if (stateNext == ST_SUSP || stateNext == ST_IDLE) suspPend <= 1'b0;
      else if (busy && suspCmd)                         suspPend <= 1'b1;
    end
  end

endmodule

// File: rtl/sector_erase_ctrl.sv
module sector_erase_ctrl
  import sec_erase_pkg::*;
#(
  parameter int NUM_SECTORS = 64,
  parameter int MAX_STEPS   = 32,
  parameter int STEP_CYCLES = 8,
  localparam int SECT_W = $clog2(NUM_SECTORS),
  localparam int STEP_W = $clog2(MAX_STEPS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdValid,
  input  logic [1:0]             cmdOp,
  input  logic [SECT_W-1:0]      cmdSector,
  input  logic [NUM_SECTORS-1:0] protMask,
  input  logic                   verifyPass,
  output logic                   busy,
  output logic                   suspended,
  output logic                   protReject,
  output logic                   eraseError,
  output logic                   biasOn,
  output logic [STEP_W-1:0]      biasLevel,
  output logic                   verifyReq,
  output logic [SECT_W-1:0]      activeSector
);

  dpStrobeT strobe;
  logic sectorProt, timerZero, stepLast;

  sec_erase_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp),
    .sectorProt (sectorProt),
    .timerZero  (timerZero),
    .stepLast   (stepLast),
    .verifyPass (verifyPass),
    .strobe     (strobe),
    .busy       (busy),
    .suspended  (suspended),
    .biasOn     (biasOn),
    .verifyReq  (verifyReq)
  );

  sec_erase_dp #(
    .NUM_SECTORS (NUM_SECTORS),
    .MAX_STEPS   (MAX_STEPS),
    .STEP_CYCLES (STEP_CYCLES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cmdSector    (cmdSector),
    .protMask     (protMask),
    .sectorProt   (sectorProt),
    .timerZero    (timerZero),
    .stepLast     (stepLast),
    .stepIdx      (biasLevel),
    .activeSector (activeSector),
    .protReject   (protReject),
    .eraseError   (eraseError)
  );

endmodule

// File: rtl/sec_erase_chk.sv
module sec_erase_chk #(
  parameter int NUM_SECTORS = 64,
  parameter int MAX_STEPS   = 32,
  parameter int STEP_CYCLES = 8,
  localparam int SECT_W = $clog2(NUM_SECTORS),
  localparam int STEP_W = $clog2(MAX_STEPS)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   cmdValid,
  input logic [1:0]             cmdOp,
  input logic [SECT_W-1:0]      cmdSector,
  input logic [NUM_SECTORS-1:0] protMask,
  input logic                   verifyPass,
  input logic                   busy,
  input logic                   suspended,
  input logic                   protReject,
  input logic                   eraseError,
  input logic                   biasOn,
  input logic [STEP_W-1:0]      biasLevel,
  input logic                   verifyReq,
  input logic [SECT_W-1:0]      activeSector
);

  logic idleErase;
  assign idleErase = cmdValid && (cmdOp == 2'b01) && !busy && !suspended;

  p_reject_protected_r2: assert property (@(posedge clk) disable iff (!rstN)
    idleErase && protMask[cmdSector] |=> protReject && !busy);

  p_start_level_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    idleErase && !protMask[cmdSector] |=> busy && biasOn && (biasLevel == '0));

  p_level_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> (biasLevel == $past(biasLevel)) ||
                            (biasLevel == $past(biasLevel) + 1'b1));

  p_verify_after_bias_r4: assert property (@(posedge clk) disable iff (!rstN)
    verifyReq |-> $past(biasOn));

  p_pass_ends_r4: assert property (@(posedge clk) disable iff (!rstN)
    verifyReq && verifyPass |=> !busy && !eraseError && !suspended);

  p_error_last_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eraseError) |-> !busy && ($past(biasLevel) == STEP_W'(MAX_STEPS - 1)));

  p_sector_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy || suspended) && ($past(busy) || $past(suspended)) |-> $stable(activeSector));

  p_park_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    suspended |-> !busy && !biasOn && !verifyReq);

  p_level_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    suspended && $past(suspended) |-> $stable(biasLevel));

  p_resume_same_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    suspended && cmdValid && (cmdOp == 2'b11) |=> biasOn && $stable(biasLevel));

  p_idle_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !suspended && cmdValid && (cmdOp[1] == 1'b1) |=> !busy && !suspended);

endmodule

bind sector_erase_ctrl sec_erase_chk #(
  .NUM_SECTORS (NUM_SECTORS),
  .MAX_STEPS   (MAX_STEPS),
  .STEP_CYCLES (STEP_CYCLES)
) u_chk (.*);

// File: tb/sector_erase_ctrl_tb.sv
`timescale 1ns/100ps
module sector_erase_ctrl_tb;

  localparam int NUM_SECTORS = 64;
  localparam int MAX_STEPS   = 32;
  localparam int STEP_CYCLES = 8;
  localparam int SECT_W = $clog2(NUM_SECTORS);
  localparam int STEP_W = $clog2(MAX_STEPS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'b00;
  logic [SECT_W-1:0] cmdSector = '0;
  logic [NUM_SECTORS-1:0] protMask = '0;
  logic verifyPass;
  logic busy, suspended, protReject, eraseError, biasOn, verifyReq;
  logic [STEP_W-1:0] biasLevel;
  logic [SECT_W-1:0] activeSector;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int passAt = 0;
  int vDone = 0;

  typedef struct {
    bit err;
    int lastLvl;
    int nVer;
    int sector;
  } expT;
  expT expQ[$];

  int mVer = 0;
  int mLastLvl = 0;
  int biasRun = 0;
  bit prevBusy = 1'b0;

  always #2 clk = ~clk;

  sector_erase_ctrl #(
    .NUM_SECTORS (NUM_SECTORS),
    .MAX_STEPS   (MAX_STEPS),
    .STEP_CYCLES (STEP_CYCLES)
  ) u_dut (
    .clk (clk), .rstN (rstN), .cmdValid (cmdValid), .cmdOp (cmdOp),
    .cmdSector (cmdSector), .protMask (protMask), .verifyPass (verifyPass),
    .busy (busy), .suspended (suspended), .protReject (protReject),
    .eraseError (eraseError), .biasOn (biasOn), .biasLevel (biasLevel),
    .verifyReq (verifyReq), .activeSector (activeSector)
  );

  // verify responder: passes on verify number passAt (0 = never)
  assign verifyPass = verifyReq && (passAt != 0) && (vDone + 1 >= passAt);

  always @(posedge clk) begin
    if (cmdValid && cmdOp == 2'b01 && !busy && !suspended) vDone <= 0;
    else if (verifyReq) vDone <= vDone + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: per-step checks and scoreboard pop at completion
  always @(negedge clk) begin
    if (rstN) begin
      if (verifyReq) begin
        check(biasRun == STEP_CYCLES, "R3", "bias cycles per step", biasRun, STEP_CYCLES);
        check(int'(biasLevel) == mVer, "R3", "level at verify", int'(biasLevel), mVer);
        mLastLvl = int'(biasLevel);
        mVer++;
        biasRun = 0;
      end
      if (biasOn) biasRun++;
      if (suspended) biasRun = 0;
      if (prevBusy && !busy && !suspended) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R4", "unexpected completion", 1, 0);
        end else begin
          expT e;
          e = expQ.pop_front();
          check(eraseError == e.err, e.err ? "R5" : "R4", "error flag", int'(eraseError), int'(e.err));
          check(mLastLvl == e.lastLvl, e.err ? "R5" : "R4", "last level", mLastLvl, e.lastLvl);
          check(mVer == e.nVer, e.err ? "R5" : "R4", "verify count", mVer, e.nVer);
          check(int'(activeSector) == e.sector, "R6", "sector", int'(activeSector), e.sector);
        end
        mVer = 0;
        biasRun = 0;
      end
      prevBusy = busy;
    end
  end

  task automatic tick();
    @(negedge clk);
    #0.5;
  endtask

  task automatic send(input logic [1:0] op, input int sector);
    cmdValid  = 1'b1;
    cmdOp     = op;
    cmdSector = SECT_W'(sector);
    tick();
    cmdValid  = 1'b0;
    cmdOp     = 2'b00;
  endtask

  task automatic start_erase(input int sector, input int pAt, input bit expErr,
                             input int expLvl, input int expVer);
    expT e;
    e.err = expErr; e.lastLvl = expLvl; e.nVer = expVer; e.sector = sector;
    expQ.push_back(e);
    passAt = pAt;
    send(2'b01, sector);
  endtask

  task automatic wait_done();
    while (busy || suspended) tick();
    tick();
  endtask

  initial begin
    protMask = '0;
    protMask[5]  = 1'b1;
    protMask[40] = 1'b1;
    repeat (3) tick();
    // R1 reset state
    check(!busy && !suspended, "R1", "busy/suspended after reset", int'(busy | suspended), 0);
    check(!protReject && !eraseError, "R1", "flags after reset", int'(protReject | eraseError), 0);
    check(!biasOn && !verifyReq, "R1", "bias/verify after reset", int'(biasOn | verifyReq), 0);
    rstN = 1'b1;
    tick();

    // R2 protected sector refused
    send(2'b01, 5);
    check(protReject == 1'b1, "R2", "protReject on protected", int'(protReject), 1);
    check(busy == 1'b0, "R2", "busy after reject", int'(busy), 0);
    tick();
    check(busy == 1'b0 && activeSector == '0, "R2", "no erase started", int'(activeSector), 0);

    // R3/R4 normal erase, pass on verify 4; accepted erase clears reject (R2)
    start_erase(3, 4, 1'b0, 3, 4);
    check(protReject == 1'b0, "R2", "reject cleared by accepted erase", int'(protReject), 0);
    check(busy && biasOn, "R3", "busy and bias next cycle", int'(busy & biasOn), 1);
    check(biasLevel == '0, "R3", "first level", int'(biasLevel), 0);
    repeat (4) tick();
    // R6 erase while busy ignored, even for a protected sector
    send(2'b01, 7);
    check(int'(activeSector) == 3, "R6", "sector after busy erase", int'(activeSector), 3);
    send(2'b01, 40);
    check(protReject == 1'b0, "R6", "no reject while busy", int'(protReject), 0);
    wait_done();

    // R5 never passes
    start_erase(12, 0, 1'b1, MAX_STEPS - 1, MAX_STEPS);
    wait_done();
    check(eraseError == 1'b1 && busy == 1'b0, "R5", "error after last step", int'(eraseError), 1);

    // R7/R8 suspend mid-step, resume same step
    start_erase(9, 6, 1'b0, 5, 6);
    while (!(biasOn && biasLevel == 2)) tick();
    repeat (3) tick();
    send(2'b10, 0);
    for (int i = 0; i < STEP_CYCLES + 2 && !suspended; i++) tick();
    check(suspended == 1'b1, "R7", "parked at step end", int'(suspended), 1);
    check(int'(biasLevel) == 2, "R7", "level at park", int'(biasLevel), 2);
    check(!biasOn && !busy, "R7", "bias off while parked", int'(biasOn | busy), 0);
    check(mVer == 2, "R7", "no verify for parked step", mVer, 2);
    repeat (10) tick();
    check(suspended && int'(biasLevel) == 2, "R7", "level held while parked", int'(biasLevel), 2);
    send(2'b01, 1);
    check(int'(activeSector) == 9 && suspended, "R6", "erase ignored while parked", int'(activeSector), 9);
    send(2'b11, 0);
    check(busy && biasOn, "R8", "bias back after resume", int'(busy & biasOn), 1);
    check(int'(biasLevel) == 2, "R8", "same step after resume", int'(biasLevel), 2);
    wait_done();

    // R9 idle suspend/resume ignored, no stale request
    send(2'b10, 0);
    check(!suspended && !busy, "R9", "suspend while idle", int'(suspended | busy), 0);
    send(2'b11, 0);
    check(!suspended && !busy, "R9", "resume while idle", int'(suspended | busy), 0);
    start_erase(20, 3, 1'b0, 2, 3);
    repeat (STEP_CYCLES + 2) tick();
    check(!suspended, "R9", "no stale suspend", int'(suspended), 0);
    wait_done();

    // R4 pass on first verify, second protected sector refused
    start_erase(63, 1, 1'b0, 0, 1);
    wait_done();
    send(2'b01, 40);
    check(protReject == 1'b1 && !busy, "R2", "reject sector 40", int'(protReject), 1);

    check(expQ.size() == 0, "R4", "scoreboard drained", expQ.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule